// File: doc/BRIEF.md
# On-Screen Display Line-Pattern Shift Engine

This block produces the serial pixel stream of a simple on-screen display overlay. A processor writes a 64-pixel line pattern, one byte at a time, into a staging register. At the end of every group of N video lines the staged pattern is copied as a whole into the active pattern. On every line of the group that falls inside the display window, the active pattern is shifted out one pixel per clock, starting on the clock after the line sync edge. The group height N is 4, 5 or 6 lines, so each displayed dot is N lines tall. The enabled colour outputs follow the pixel.

A frame sync edge restarts the line and group counters. The display window is given in whole groups. When the timing outputs are enabled, the block gives the processor two pulses to pace its loads. The first is one active-low frame pulse per frame, one group ahead of the window. The second is a one-clock interrupt at the start of each group whose following group lies inside the window. When the timing outputs are off, a pattern loaded once is simply repeated over the whole window. The pixel oscillator is modelled as the block clock.

Top module: `osd_line_engine`

## Requirements
- R1: During and right after reset, pix_out and colour_out are 0, frame_n is 1, irq is 0, and the staged and active patterns are all zero.
- R2: n_sel selects the group height: 0 gives 4 lines, 1 gives 5 lines, 2 gives 6 lines (3 behaves as 0). The active pattern is replaced at the first line start after a frame sync and then at every N-th line start after that.
- R3: A line start is a rising edge of hsync sampled on clk. On a line start inside the window, bit k of the active pattern (bit 0 first) appears on pix_out in the k-th cycle after that clock edge, for k = 0..63. After that pix_out is 0. On lines outside the window pix_out stays 0.
- R4: A rising edge of ld_active clears the staging register and its byte count. While ld_active is 1, each ld_valid cycle writes ld_byte into bits 8i+7..8i, where i is the number of bytes already taken since the rise. Bytes after the eighth are ignored, and so are ld_valid cycles while ld_active is 0.
- R5: If ld_active drops after fewer than 8 bytes, the staging bits that were not written stay zero.
- R6: The staging register is copied into the active pattern only on a group-boundary line start, and the same pattern is shown on every window line of that group. A byte taken on the same clock as the copy is not part of the copied pattern; it shows from the next group on.
- R7: Groups are numbered from 0, group 0 being the one that starts at the first line start after a frame sync. The window covers groups win_start up to and including win_end-1.
- R8: With timing_en at 1, frame_n goes low for FP_LEN clocks, beginning in the cycle after the line start of group win_start-1. With timing_en at 0, frame_n stays 1.
- R9: With timing_en at 1, irq is a one-clock pulse in the cycle after the line start of every group g with win_start-1 <= g <= win_end-2. With timing_en at 0, irq stays 0.
- R10: colour_out bit c equals colour_en bit c AND pix_out.
- R11: A rising edge of vsync in the middle of a group abandons that group, so the next line start begins group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Line sync; a rising edge starts a line |
| vsync | input | 1 | Frame sync; a rising edge restarts the counters |
| ld_active | input | 1 | Pattern-load state, high while both processor strobes are low |
| ld_valid | input | 1 | A pattern byte is presented this cycle |
| ld_byte | input | 8 | Pattern byte |
| n_sel | input | 2 | Group height select (4, 5 or 6 lines) |
| win_start | input | 6 | First window group |
| win_end | input | 6 | Group just after the last window group |
| timing_en | input | 1 | Enables the frame pulse and the interrupt |
| colour_en | input | 3 | Per-colour output enable |
| pix_out | output | 1 | Serial pixel |
| colour_out | output | 3 | Gated colour outputs |
| frame_n | output | 1 | Active-low frame pulse |
| irq | output | 1 | Per-group interrupt pulse |

## Verification
Two things can land on one clock edge: the group-boundary copy of the staging register and the processor writing a pattern byte. The bench provokes this by starting a load, writing seven bytes, and then presenting the eighth byte on the very clock that carries the hsync edge opening a new group. It expects that group to show the pattern with its top byte zero, and the following group to show all eight bytes. A second overlap also occurs in the same frame: the frame pulse and the first interrupt both start from the line start of group win_start-1. Both are judged on that same line.

// File: rtl/osd_pkg.sv
package osd_pkg;

  // Lines per displayed dot for a given select code.
  function automatic logic [2:0] group_height(input logic [1:0] sel);
    case (sel)
      2'd1:    return 3'd5;
      2'd2:    return 3'd6;
      default: return 3'd4;
    endcase
  endfunction

  // Half-open span test: lo <= g < hi.
  function automatic logic in_span(input int unsigned g, input int unsigned lo,
                                   input int unsigned hi);
    return (g >= lo) && (g < hi);
  endfunction

endpackage

// File: rtl/osd_line_timer.sv
module osd_line_timer #(
  parameter int GRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [1:0]       n_sel,
  output logic             line_start,
  output logic             grp_adv,
  output logic [GRP_W-1:0] grp_line
);
  import osd_pkg::*;

  logic             hs_q, vs_q, fresh;
  logic [2:0]       lcnt;
  logic [GRP_W-1:0] grp_now, grp_next;
  logic             vs_rise;

  assign vs_rise    = vsync & ~vs_q;
  assign line_start = hsync & ~hs_q & ~vs_rise;
  assign grp_adv    = line_start & (fresh | (lcnt == group_height(n_sel) - 3'd1));
  assign grp_next   = fresh ? '0 : grp_now + 1'b1;
  assign grp_line   = grp_adv ? grp_next : grp_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      fresh   <= 1'b1;
      lcnt    <= '0;
      grp_now <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (vs_rise) begin
        fresh <= 1'b1;
        lcnt  <= '0;
      end else if (grp_adv) begin
        fresh   <= 1'b0;
        lcnt    <= '0;
        grp_now <= grp_next;
      end else if (line_start) begin
        lcnt <= lcnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/osd_pattern_stage.sv
module osd_pattern_stage #(
  parameter int PAT_BITS = 64,
  parameter int BYTE_W   = 8,
  localparam int NBYTES  = PAT_BITS / BYTE_W,
  localparam int SLOT_W  = $clog2(NBYTES),
  localparam int CNT_W   = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_active,
  input  logic                ld_valid,
  input  logic [BYTE_W-1:0]   ld_byte,
  output logic [PAT_BITS-1:0] stage,
  output logic [CNT_W-1:0]    byte_cnt
);
  logic              ld_q, ld_rise, take;
  logic [SLOT_W-1:0] slot;

  assign ld_rise = ld_active & ~ld_q;
  assign take    = ld_valid & ld_active & (ld_rise | (byte_cnt < CNT_W'(NBYTES)));
  assign slot    = ld_rise ? '0 : byte_cnt[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_q     <= 1'b0;
      stage    <= '0;
      byte_cnt <= '0;
    end else begin
      ld_q <= ld_active;
      if (ld_rise) begin
        stage    <= '0;
        byte_cnt <= '0;
      end
      if (take) begin
        for (int i = 0; i < NBYTES; i++)
          if (32'(slot) == i) stage[i*BYTE_W +: BYTE_W] <= ld_byte;
        byte_cnt <= CNT_W'(slot) + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/osd_window_timing.sv
module osd_window_timing #(
  parameter int GRP_W  = 6,
  parameter int FP_LEN = 45,
  localparam int FP_W  = $clog2(FP_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_adv,
  input  logic [GRP_W-1:0] grp_line,
  input  logic [GRP_W-1:0] win_start,
  input  logic [GRP_W-1:0] win_end,
  input  logic             timing_en,
  output logic             in_win,
  output logic             frame_n,
  output logic             irq
);
  import osd_pkg::*;

  logic [FP_W-1:0] fp_cnt;
  int unsigned     lead;
  logic            fire_frame, fire_irq;

  // The group that opens N lines after this one.
  assign lead       = 32'(grp_line) + 1;
  assign in_win     = in_span(32'(grp_line), 32'(win_start), 32'(win_end));
  assign fire_frame = grp_adv & timing_en & (lead == 32'(win_start));
  assign fire_irq   = grp_adv & timing_en & in_span(lead, 32'(win_start), 32'(win_end));
  assign frame_n    = (fp_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_cnt <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= fire_irq;
      if (fire_frame)          fp_cnt <= FP_W'(FP_LEN);
      else if (fp_cnt != '0)   fp_cnt <= fp_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/osd_pixel_shifter.sv
module osd_pixel_shifter #(
  parameter int PAT_BITS = 64,
  parameter int COL_W    = 3,
  localparam int IDX_W   = $clog2(PAT_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic                grp_adv,
  input  logic                in_win,
  input  logic [PAT_BITS-1:0] stage,
  input  logic [COL_W-1:0]    colour_en,
  output logic [PAT_BITS-1:0] act_pat,
  output logic                pix_out,
  output logic [COL_W-1:0]    colour_out
);
  logic [PAT_BITS-1:0] shreg;
  logic [IDX_W-1:0]    idx;
  logic                run;

  assign pix_out    = run & shreg[0];
  assign colour_out = colour_en & {COL_W{pix_out}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pat <= '0;
      shreg   <= '0;
      idx     <= '0;
      run     <= 1'b0;
    end else begin
      if (grp_adv) act_pat <= stage;
      if (line_start) begin
        shreg <= grp_adv ? stage : act_pat;
        run   <= in_win;
        idx   <= '0;
      end else if (run) begin
        shreg <= shreg >> 1;
        idx   <= idx + 1'b1;
        if (idx == IDX_W'(PAT_BITS - 1)) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/osd_line_engine.sv
module osd_line_engine #(
  parameter int PAT_BITS = 64,
  parameter int BYTE_W   = 8,
  parameter int GRP_W    = 6,
  parameter int COL_W    = 3,
  parameter int FP_LEN   = 45,
  localparam int CNT_W   = $clog2(PAT_BITS / BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              ld_active,
  input  logic              ld_valid,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic [1:0]        n_sel,
  input  logic [GRP_W-1:0]  win_start,
  input  logic [GRP_W-1:0]  win_end,
  input  logic              timing_en,
  input  logic [COL_W-1:0]  colour_en,
  output logic              pix_out,
  output logic [COL_W-1:0]  colour_out,
  output logic              frame_n,
  output logic              irq
);
  logic                line_start, grp_adv, in_win;
  logic [GRP_W-1:0]    grp_line;
  logic [PAT_BITS-1:0] stage, act_pat;
  logic [CNT_W-1:0]    byte_cnt;

  osd_line_timer #(.GRP_W(GRP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .n_sel(n_sel),
    .line_start(line_start), .grp_adv(grp_adv), .grp_line(grp_line));

  osd_pattern_stage #(.PAT_BITS(PAT_BITS), .BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .ld_active(ld_active), .ld_valid(ld_valid),
    .ld_byte(ld_byte), .stage(stage), .byte_cnt(byte_cnt));

  osd_window_timing #(.GRP_W(GRP_W), .FP_LEN(FP_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .grp_adv(grp_adv), .grp_line(grp_line),
    .win_start(win_start), .win_end(win_end), .timing_en(timing_en),
    .in_win(in_win), .frame_n(frame_n), .irq(irq));

  osd_pixel_shifter #(.PAT_BITS(PAT_BITS), .COL_W(COL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .grp_adv(grp_adv),
    .in_win(in_win), .stage(stage), .colour_en(colour_en), .act_pat(act_pat),
    .pix_out(pix_out), .colour_out(colour_out));
endmodule

// File: rtl/osd_line_engine_chk.sv
module osd_line_engine_chk #(
  parameter int PAT_BITS = 64,
  parameter int COL_W    = 3,
  parameter int CNT_W    = 4,
  parameter int NBYTES   = 8,
  localparam int SW      = $clog2(PAT_BITS) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_start,
  input logic                grp_adv,
  input logic                pix_out,
  input logic [COL_W-1:0]    colour_out,
  input logic                irq,
  input logic                frame_n,
  input logic                timing_en,
  input logic [PAT_BITS-1:0] act_pat,
  input logic [CNT_W-1:0]    byte_cnt
);
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                      since <= SW'(PAT_BITS);
    else if (line_start)             since <= '0;
    else if (since != SW'(PAT_BITS)) since <= since + 1'b1;
  end

  // R3
  pix_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out |-> (since < SW'(PAT_BITS)));

  // R10
  colour_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_out |-> (colour_out == '0));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(timing_en));

  // R8
  frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(timing_en));

  // R6
  xfer_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pat != $past(act_pat)) |-> $past(grp_adv));

  // R4
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(NBYTES));
endmodule

bind osd_line_engine osd_line_engine_chk #(
  .PAT_BITS(PAT_BITS), .COL_W(COL_W), .CNT_W(CNT_W), .NBYTES(PAT_BITS / BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .grp_adv(grp_adv),
  .pix_out(pix_out), .colour_out(colour_out), .irq(irq), .frame_n(frame_n),
  .timing_en(timing_en), .act_pat(act_pat), .byte_cnt(byte_cnt));

// File: tb/osd_line_engine_bench.sv
`timescale 1ns/1ps
module osd_line_engine_bench;
  localparam int FP = 45;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, ld_active = 1'b0, ld_valid = 1'b0;
  logic [7:0] ld_byte = '0;
  logic [1:0] n_sel = '0;
  logic [5:0] win_start = '0, win_end = '0;
  logic       timing_en = 1'b0;
  logic [2:0] colour_en = '0;
  logic       pix_out, frame_n, irq;
  logic [2:0] colour_out;

  always #2.5 clk = ~clk;

  osd_line_engine #(.FP_LEN(FP)) u_osd_line_engine (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .ld_active(ld_active),
    .ld_valid(ld_valid), .ld_byte(ld_byte), .n_sel(n_sel), .win_start(win_start),
    .win_end(win_end), .timing_en(timing_en), .colour_en(colour_en),
    .pix_out(pix_out), .colour_out(colour_out), .frame_n(frame_n), .irq(irq));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // Reference model state, written from the requirements.
  logic [63:0] m_stage = '0, m_act = '0;
  int m_bcnt = 0, m_l = 0, m_g = 0, m_n = 4;
  bit m_fresh = 1'b1;
  string cur_tag = "R1";

  logic [63:0] q_pat[$];
  bit          q_irq[$];
  bit          q_frm[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic model_byte(input logic [7:0] b);
    if (m_bcnt < 8) begin
      m_stage[m_bcnt*8 +: 8] = b;
      m_bcnt++;
    end
  endtask

  // Scoreboard driver: predict the line, queue it, then drive the sync edge.
  task automatic hline(input bit with_byte, input logic [7:0] b);
    bit adv, ei, ef;
    int ws, we;
    ws = int'(win_start); we = int'(win_end);
    adv = m_fresh || (m_l == m_n - 1);
    ei = 1'b0; ef = 1'b0;
    if (adv) begin
      m_g = m_fresh ? 0 : m_g + 1;
      m_fresh = 1'b0; m_l = 0; m_act = m_stage;
      ei = timing_en && (m_g + 1 >= ws) && (m_g + 1 < we);
      ef = timing_en && (m_g + 1 == ws);
    end else m_l++;
    q_pat.push_back((m_g >= ws && m_g < we) ? m_act : 64'd0);
    q_irq.push_back(ei);
    q_frm.push_back(ef);
    q_tag.push_back(cur_tag);
    hsync = 1'b1;
    if (with_byte) begin
      ld_valid = 1'b1; ld_byte = b; model_byte(b);
    end
    tick;
    hsync = 1'b0; ld_valid = 1'b0;
    repeat (79) tick;
  endtask

  task automatic lines(input int k);
    for (int i = 0; i < k; i++) hline(1'b0, 8'h00);
  endtask

  task automatic frame_sync;
    vsync = 1'b1; tick; vsync = 1'b0; tick;
    m_fresh = 1'b1; m_l = 0;
  endtask

  task automatic ld_begin;
    ld_active = 1'b1; m_stage = '0; m_bcnt = 0; tick;
  endtask

  task automatic ld_bytes(input int k, input logic [7:0] base);
    for (int i = 0; i < k; i++) begin
      ld_valid = 1'b1; ld_byte = base + 8'(i); model_byte(base + 8'(i)); tick;
    end
    ld_valid = 1'b0;
  endtask

  task automatic ld_end; ld_active = 1'b0; tick; endtask

  // Scoreboard monitor: capture each line and compare with the queued item.
  initial begin
    forever begin
      logic [63:0] got, ep;
      bit tail_ok, col_ok, ei, ef, irq0, irq1;
      int lows;
      string tg;
      @(posedge hsync);
      ep = q_pat.pop_front(); ei = q_irq.pop_front();
      ef = q_frm.pop_front(); tg = q_tag.pop_front();
      got = '0; tail_ok = 1'b1; col_ok = 1'b1; lows = 0; irq0 = 1'b0; irq1 = 1'b0;
      for (int k = 0; k < 70; k++) begin
        @(negedge clk);
        if (k < 64) got[k] = pix_out;
        else if (pix_out) tail_ok = 1'b0;
        if (colour_out != (colour_en & {3{pix_out}})) col_ok = 1'b0;
        if (!frame_n) lows++;
        if (k == 0) irq0 = irq;
        if (k == 1) irq1 = irq;
      end
      check(got == ep && tail_ok, {tg, " R3 pixel pattern"}, "pattern", got, ep);
      check(col_ok, "R10", "colour gating", col_ok, 1);
      check(irq0 == ei && !irq1, {tg, " R9"}, "irq", {irq0, irq1}, {ei, 1'b0});
      check(lows == (ef ? FP : 0), {tg, " R8"}, "frame low cycles", lows, ef ? FP : 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    check(pix_out == 1'b0 && colour_out == 3'b0, "R1", "pixel in reset", pix_out, 0);
    check(frame_n && !irq, "R1", "pulses in reset", {frame_n, irq}, 2'b10);
    rst_n = 1'b1;
    tick;
    check(pix_out == 1'b0 && frame_n && !irq, "R1", "after reset",
          {pix_out, frame_n, irq}, 3'b010);

    // Frame A: N = 4, window groups 2..4, timing outputs on.
    n_sel = 2'd0; m_n = 4; win_start = 6'd2; win_end = 6'd5;
    timing_en = 1'b1; colour_en = 3'b101;
    frame_sync;
    cur_tag = "R2 R7";
    ld_begin; ld_bytes(8, 8'h11); ld_end;
    lines(5);
    cur_tag = "R5 partial load";
    ld_begin; ld_bytes(3, 8'hA0); ld_end;
    lines(4);
    cur_tag = "R6 boundary collision";
    ld_begin; ld_bytes(7, 8'h30);
    lines(3);
    hline(1'b1, 8'h37);
    cur_tag = "R4 ninth byte";
    ld_bytes(1, 8'h99); ld_end;
    lines(15);

    // Frame B: N = 5, timing off, stray byte without the load state.
    cur_tag = "R4 R8 timing off";
    n_sel = 2'd1; m_n = 5; win_start = 6'd1; win_end = 6'd3; timing_en = 1'b0;
    frame_sync;
    ld_valid = 1'b1; ld_byte = 8'hFF; tick; ld_valid = 1'b0;
    lines(22);

    // Frame C: N = 6, sync arrives mid-group of the previous frame.
    cur_tag = "R11 R2 N=6";
    n_sel = 2'd2; m_n = 6; win_start = 6'd1; win_end = 6'd2; timing_en = 1'b1;
    colour_en = 3'b011;
    frame_sync;
    lines(18);

    repeat (5) tick;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule